// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block runs an external dual-slope integrating converter through its four conversion phases. It divides its oscillator clock by four to form a system tick and times every phase in those ticks. It drives the two-bit phase code onto pins A and B and watches the converter's zero-crossing comparator.

The auto-zero and integrate phases each last a span set by an 8-bit load value. De-integrate runs until the comparator falls, and the block counts its ticks into a 16-bit result. Integrator-zero runs until the comparator rises again. When a finished conversion gives way to the next auto-zero, the block publishes a result word to the serial port that sits beside it. The word holds an overrange flag, the polarity and the count.

A level enable input, `run_n`, halts conversion while it is high and holds the converter in auto-zero. The active-low `dv_n` output is low whenever the phase is auto-zero. The result leaves on a valid/ready stream. `res_valid` stays high and `res_data` stays unchanged until `res_ready` is seen high. The sequencer never waits for the consumer: a word that has not been taken when the next conversion completes is replaced by the newer one, and `res_valid` stays high.

Top module: `dsq_phase_seq`

## Requirements
- R1: The phase code {phase_a, phase_b} is 01 for auto-zero, 10 for integrate, 11 for de-integrate and 00 for integrator-zero. After reset the code is 00, dv_n is 1 and res_valid is 0.
- R2: Integrator-zero holds while cmp_i is low and exits to auto-zero on the first system tick that samples cmp_i high.
- R3: With run_n low the phases follow the order auto-zero, integrate, de-integrate, integrator-zero, then auto-zero again. The code never changes in any other way except by jumping to 01.
- R4: The system tick is one clk_osc cycle in every DIV (4). Every phase boundary falls on a tick, so every phase that is entered normally lasts a whole number of 4-clock ticks.
- R5: Auto-zero and integrate each last (2^LV_W − L)·2^FINE_W ticks, where L is load_val latched on entry to auto-zero. With the defaults, FFh gives 256 ticks, 80h gives 32768 and 00h gives 65536.
- R6: The de-integrate count is the number of ticks spent in de-integrate before the tick that detects cmp_i falling from high to low. De-integrate therefore lasts count+1 ticks, and it then passes to integrator-zero.
- R7: If de-integrate spends 2^RES_W ticks without a comparator fall, the phase ends with overrange set and the count saturated to all ones.
- R8: Polarity is the level of cmp_i at the last tick of integrate, where 1 means a positive input.
- R9: While run_n is high, the code becomes 01 on the next clock and stays there. The auto-zero span restarts when run_n is released, and a conversion cut short by run_n is never published.
- R10: dv_n is 0 exactly while the phase code is 01.
- R11: A word is published only on the step from integrator-zero to auto-zero after a completed de-integrate. The layout is bit RES_W+1 = overrange, bit RES_W = polarity, bits RES_W−1:0 = count. The first auto-zero after reset publishes nothing.
- R12: res_valid holds, with res_data stable, until res_ready is high at a clock edge. A new publication replaces an untaken word and keeps res_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; the system tick is derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_n | input | 1 | Level enable; high halts conversion and forces auto-zero |
| cmp_i | input | 1 | Zero-crossing comparator from the converter |
| load_val | input | LV_W | Programmable upper part of the phase span |
| phase_a | output | 1 | Phase code, upper bit |
| phase_b | output | 1 | Phase code, lower bit |
| dv_n | output | 1 | Low while in auto-zero |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer takes the word at a clock edge |
| res_data | output | RES_W+2 | {overrange, polarity, count} |

## Verification
The hardest case to reach is overrange. It needs a de-integrate phase with no comparator fall for the full counter length, which at default widths means more than a quarter million clocks. The bench therefore narrows the count to 10 bits and the fixed span part to 2 bits, then holds cmp_i high through de-integrate until the block ends the phase itself. Negative polarity needs a real falling edge after the comparator was sampled low at the end of integrate, so the bench raises and then lowers cmp_i inside de-integrate. An abort is reached by raising run_n in the middle of de-integrate and checking that no word appears at the auto-zero that follows.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    PH_IZ    = 2'b00,
    PH_AZ    = 2'b01,
    PH_INT   = 2'b10,
    PH_DEINT = 2'b11
  } phase_e;
endpackage

// File: rtl/dsq_tick_div.sv
module dsq_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dsq_span_timer.sv
module dsq_span_timer #(
  parameter int LV_W   = 8,
  parameter int FINE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            reload,
  input  logic            take_new,
  input  logic            run_en,
  input  logic [LV_W-1:0] lv_i,
  output logic            done
);
  localparam int TW = LV_W + FINE_W;

  logic [LV_W-1:0] lv_q;
  logic [TW-1:0]   cnt_q;
  logic [LV_W-1:0] lv_sel;

  assign lv_sel = take_new ? lv_i : lv_q;
  assign done   = tick && run_en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q  <= '0;
      cnt_q <= '0;
    end else if (reload) begin
      if (take_new) lv_q <= lv_i;
      // span minus one: complement of the load value above an all-ones fine part
      cnt_q <= {~lv_sel, {FINE_W{1'b1}}};
    end else if (tick && run_en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dsq_deint_cnt.sv
module dsq_deint_cnt #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [RES_W-1:0] cnt,
  output logic             full
);
  logic [RES_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign full = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc && !full) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dsq_seq_fsm.sv
module dsq_seq_fsm
  import dsq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   run_n,
  input  logic   cmp_i,
  input  logic   span_done,
  input  logic   cnt_full,
  output phase_e state,
  output logic   tmr_reload,
  output logic   tmr_take_new,
  output logic   tmr_run,
  output logic   cnt_clr,
  output logic   cnt_inc,
  output logic   publish,
  output logic   ovr,
  output logic   pol
);
  phase_e state_q, state_d;
  logic   cmp_q;
  logic   pend_q, pend_d;
  logic   ovr_q, ovr_d;
  logic   pol_q, pol_d;
  logic   fall;

  assign fall  = tick && cmp_q && !cmp_i;
  assign state = state_q;
  assign ovr   = ovr_q;
  assign pol   = pol_q;

  always_comb begin
    state_d      = state_q;
    pend_d       = pend_q;
    ovr_d        = ovr_q;
    pol_d        = pol_q;
    tmr_reload   = 1'b0;
    tmr_take_new = 1'b0;
    cnt_clr      = 1'b0;
    cnt_inc      = 1'b0;
    publish      = 1'b0;
    tmr_run      = !run_n && (state_q == PH_AZ || state_q == PH_INT);
    if (run_n) begin
      state_d      = PH_AZ;
      tmr_reload   = 1'b1;
      tmr_take_new = 1'b1;
      pend_d       = 1'b0;
    end else begin
      unique case (state_q)
        PH_IZ: begin
          if (tick && cmp_i) begin
            state_d      = PH_AZ;
            tmr_reload   = 1'b1;
            tmr_take_new = 1'b1;
            publish      = pend_q;
            pend_d       = 1'b0;
          end
        end
        PH_AZ: begin
          if (span_done) begin
            state_d    = PH_INT;
            tmr_reload = 1'b1;
          end
        end
        PH_INT: begin
          if (span_done) begin
            state_d = PH_DEINT;
            cnt_clr = 1'b1;
            pol_d   = cmp_i;
          end
        end
        PH_DEINT: begin
          if (fall) begin
            state_d = PH_IZ;
            pend_d  = 1'b1;
            ovr_d   = 1'b0;
          end else if (tick && cnt_full) begin
            state_d = PH_IZ;
            pend_d  = 1'b1;
            ovr_d   = 1'b1;
          end else begin
            cnt_inc = tick;
          end
        end
        default: state_d = PH_IZ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IZ;
      cmp_q   <= 1'b0;
      pend_q  <= 1'b0;
      ovr_q   <= 1'b0;
      pol_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      ovr_q   <= ovr_d;
      pol_q   <= pol_d;
      if (tick) cmp_q <= cmp_i;
    end
  end
endmodule

// File: rtl/dsq_result_out.sv
module dsq_result_out #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         publish,
  input  logic [W-1:0] word,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (publish) begin
      valid <= 1'b1;
      data  <= word;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dsq_phase_seq.sv
module dsq_phase_seq
  import dsq_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int LV_W   = 8,
  parameter int FINE_W = 8,
  parameter int RES_W  = 16
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             run_n,
  input  logic             cmp_i,
  input  logic [LV_W-1:0]  load_val,
  output logic             phase_a,
  output logic             phase_b,
  output logic             dv_n,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W+1:0] res_data
);
  localparam int WW = RES_W + 2;

  logic             tick;
  logic             span_done;
  logic             tmr_reload, tmr_take_new, tmr_run;
  logic             cnt_clr, cnt_inc, cnt_full;
  logic [RES_W-1:0] cnt;
  logic             publish;
  logic             ovr, pol;
  phase_e           state;
  logic [WW-1:0]    word;

  dsq_tick_div #(.DIV(DIV)) u_div (
    .clk(clk_osc), .rst_n(rst_n), .tick(tick)
  );

  dsq_span_timer #(.LV_W(LV_W), .FINE_W(FINE_W)) u_span (
    .clk(clk_osc), .rst_n(rst_n), .tick(tick), .reload(tmr_reload),
    .take_new(tmr_take_new), .run_en(tmr_run), .lv_i(load_val), .done(span_done)
  );

  dsq_deint_cnt #(.RES_W(RES_W)) u_cnt (
    .clk(clk_osc), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .full(cnt_full)
  );

  dsq_seq_fsm u_fsm (
    .clk(clk_osc), .rst_n(rst_n), .tick(tick), .run_n(run_n), .cmp_i(cmp_i),
    .span_done(span_done), .cnt_full(cnt_full), .state(state),
    .tmr_reload(tmr_reload), .tmr_take_new(tmr_take_new), .tmr_run(tmr_run),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .publish(publish), .ovr(ovr), .pol(pol)
  );

  assign word = {ovr, pol, cnt};

  dsq_result_out #(.W(WW)) u_out (
    .clk(clk_osc), .rst_n(rst_n), .publish(publish), .word(word),
    .ready(res_ready), .valid(res_valid), .data(res_data)
  );

  assign {phase_a, phase_b} = state;
  assign dv_n = (state != PH_AZ);
endmodule

// File: rtl/dsq_seq_chk.sv
module dsq_seq_chk #(
  parameter int RES_W = 16
) (
  input logic             clk_osc,
  input logic             rst_n,
  input logic             run_n,
  input logic             phase_a,
  input logic             phase_b,
  input logic             dv_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W+1:0] res_data,
  input logic             publish
);
  logic [1:0] code;
  assign code = {phase_a, phase_b};

  p_force_az_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    run_n |=> (code == 2'b01));

  p_dv_az_r10: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (dv_n == 1'b0) == (code == 2'b01));

  p_order_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (code != $past(code)) |->
      (code == 2'b01) ||
      ($past(code) == 2'b01 && code == 2'b10) ||
      ($past(code) == 2'b10 && code == 2'b11) ||
      ($past(code) == 2'b11 && code == 2'b00));

  p_hold_valid_r12: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);

  p_stable_data_r12: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (res_valid && !res_ready && !publish) |=> $stable(res_data));

  p_sat_ovr_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (res_valid && res_data[RES_W+1]) |-> (&res_data[RES_W-1:0]));

  p_pub_at_az_r11: assert property (@(posedge clk_osc) disable iff (!rst_n)
    publish |=> (code == 2'b01 && res_valid));
endmodule

bind dsq_phase_seq dsq_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk_osc(clk_osc), .rst_n(rst_n), .run_n(run_n), .phase_a(phase_a),
  .phase_b(phase_b), .dv_n(dv_n), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .publish(publish)
);

// File: tb/dsq_phase_seq_tb_top.sv
`timescale 1ns/1ps
module dsq_phase_seq_tb_top;
  localparam int RW = 10;
  localparam int FW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_n = 1'b0;
  logic cmp = 1'b0;
  logic [7:0] load = 8'hFF;
  logic pa, pb, dv_n, res_valid;
  logic res_ready = 1'b0;
  logic [RW+1:0] res_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int start_cyc = 0;
  logic [1:0] prev_code = 2'b00;
  int last_dur [4];

  always #10 clk = ~clk;

  dsq_phase_seq #(.DIV(4), .LV_W(8), .FINE_W(FW), .RES_W(RW)) dut_i (
    .clk_osc(clk), .rst_n(rst_n), .run_n(run_n), .cmp_i(cmp), .load_val(load),
    .phase_a(pa), .phase_b(pb), .dv_n(dv_n), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  wire [1:0] code = {pa, pb};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (code != prev_code) begin
      last_dur[prev_code] = cyc - start_cyc;
      start_cyc = cyc;
      prev_code = code;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_code(input logic [1:0] c);
    while (code != c) step();
  endtask

  function automatic int span_clks(input logic [7:0] lv);
    return (256 - int'(lv)) * (1 << FW) * 4;
  endfunction

  // Runs one conversion from within auto-zero to the next auto-zero and checks the word.
  task automatic conv(input logic [7:0] lv, input bit pos, input int k, input bit ovf,
                      input logic [7:0] lv_next, input bit accept, input bit skip_az);
    int d;
    int exp_cnt;
    check(dv_n == 1'b0, "R10 dv_n in auto-zero", dv_n, 0);
    wait_code(2'b10);
    if (!skip_az)
      check(last_dur[1] == span_clks(lv), "R5 auto-zero length", last_dur[1], span_clks(lv));
    check(dv_n == 1'b1, "R10 dv_n outside auto-zero", dv_n, 1);
    if (!pos) cmp = 1'b0;
    wait_code(2'b11);
    check(last_dur[2] == span_clks(lv), "R5 integrate length", last_dur[2], span_clks(lv));
    if (!ovf) begin
      if (!pos) begin
        repeat (12) step();
        cmp = 1'b1;
      end
      repeat (4 * k) step();
      cmp = 1'b0;
    end
    wait_code(2'b00);
    d = last_dur[3];
    check(d % 4 == 0 && d > 0, "R4 de-integrate whole ticks", d, 4);
    exp_cnt = d / 4 - 1;
    if (ovf) check(d == 4 * (1 << RW), "R7 overrange de-integrate length", d, 4 * (1 << RW));
    load = lv_next;
    if (!ovf) begin
      repeat (10) step();
      check(code == 2'b00, "R2 integrator-zero holds while cmp low", code, 0);
      cmp = 1'b1;
    end
    wait_code(2'b01);
    check(res_valid == 1'b1, "R11 word published at auto-zero", res_valid, 1);
    check(res_data == {ovf, pos, RW'(exp_cnt)}, "R11 R6 R8 result word",
          res_data, {ovf, pos, RW'(exp_cnt)});
    if (accept) begin
      res_ready = 1'b1;
      step();
      res_ready = 1'b0;
      check(res_valid == 1'b0, "R12 word taken", res_valid, 0);
    end
  endtask

  task automatic t_reset();
    check(code == 2'b00, "R1 reset phase code", code, 0);
    check(dv_n == 1'b1, "R1 reset dv_n", dv_n, 1);
    check(res_valid == 1'b0, "R1 reset res_valid", res_valid, 0);
    repeat (40) step();
    check(code == 2'b00, "R2 integrator-zero waits for cmp high", code, 0);
  endtask

  task automatic t_first_az();
    load = 8'hFF;
    cmp = 1'b1;
    wait_code(2'b01);
    check(res_valid == 1'b0, "R11 no word at first auto-zero", res_valid, 0);
  endtask

  task automatic t_hold();
    logic [RW+1:0] snap;
    snap = res_data;
    repeat (50) step();
    check(res_valid == 1'b1, "R12 valid held without ready", res_valid, 1);
    check(res_data == snap, "R12 data stable without ready", res_data, snap);
  endtask

  task automatic t_override();
    wait_code(2'b11);
    repeat (8) step();
    run_n = 1'b1;
    step();
    check(code == 2'b01, "R9 forced auto-zero code", code, 1);
    check(dv_n == 1'b0, "R10 dv_n during forced auto-zero", dv_n, 0);
    cmp = 1'b0;
    repeat (100) step();
    cmp = 1'b1;
    repeat (100) step();
    check(code == 2'b01, "R9 held in auto-zero while halted", code, 1);
    run_n = 1'b0;
    step();
    check(code == 2'b01, "R9 auto-zero restarts after release", code, 1);
    check(res_valid == 1'b0, "R9 aborted conversion not published", res_valid, 0);
    wait_code(2'b10);
    check(last_dur[1] >= span_clks(load), "R9 full span after release", last_dur[1], span_clks(load));
    check(res_valid == 1'b0, "R9 still nothing published", res_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired act=hang exp=progress");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_first_az();
    conv(8'hFF, 1'b1, 3, 1'b0, 8'hFE, 1'b1, 1'b0);
    conv(8'hFE, 1'b0, 5, 1'b0, 8'h80, 1'b1, 1'b0);
    conv(8'h80, 1'b1, 2, 1'b0, 8'h00, 1'b0, 1'b0);
    t_hold();
    conv(8'h00, 1'b1, 7, 1'b0, 8'hFF, 1'b1, 1'b0);
    conv(8'hFF, 1'b1, 0, 1'b1, 8'hFF, 1'b1, 1'b0);
    t_override();
    step();
    cmp = 1'b1;
    wait_code(2'b11);
    repeat (8) step();
    cmp = 1'b0;
    wait_code(2'b00);
    repeat (6) step();
    cmp = 1'b1;
    wait_code(2'b01);
    check(res_valid == 1'b1, "R11 word after resumed conversion", res_valid, 1);
    check(res_data[RW+1:RW] == 2'b01, "R8 R11 flags after resume", res_data[RW+1:RW], 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule